// File: doc/BRIEF.md
# Status Byte and Write Grant Controller

This block keeps the status/control byte of a serial nonvolatile memory and rules on every write that the command decoder asks for. The decoder hands it single-cycle requests: set or clear the write-enable latch, write the status byte with a data value, or write to a memory address. That last request goes either to the main array or to the auxiliary identification page, depending on the page-select bit. The block also sees the write-protect pin, chip select, the busy flag of the programming engine, and a pulse marking the end of each read or write operation.

For each write request the block answers with a one-cycle grant or a one-cycle deny. The answer combines the write-enable latch, the protect pin, the pin-enable bit and the block-protect field, plus the lock and page-select rules for the identification page. A status write is only armed when its request arrives. It takes effect when chip select rises, and it is cancelled if hardware protection becomes active before that rise. Nonvolatile bits are ordinary flops that take their power-up value from a parameter at reset.

Top module: `wp_status_ctl`

## Requirements
- R1: After reset the status byte equals the nonvolatile init value with bits 6, 5 and 1 at 0. Bit 0 always shows `busy_in`, and bit 5 always reads 0. Bit 7 is pin enable, bit 6 is page select, bit 4 is page lock, bits 3:2 are block protect, bit 1 is the write-enable latch and bit 0 is busy.
- R2: A `req_wren` pulse sets status bit 1 and a `req_wrdi` pulse clears it. Every granted array write, page write or status commit also clears it.
- R3: Block protect 00 protects no address and 01 protects the top quarter (0x6000..0x7FFF at 15 address bits). 10 protects the top half (0x4000..0x7FFF) and 11 protects everything. An array write is granted only with the latch set and the address unprotected.
- R4: A status write is accepted only with the latch set and hardware protection inactive. Hardware protection is active when `wp_n` is 0 and bit 7 is 1. An accepted status write changes only bits 7, 6, 4, 3 and 2, and it takes effect on the first cycle that `cs_n` is high, with a grant pulse.
- R5: A status write whose data has both bit 6 and bit 4 at 1 leaves bits 6 and 4 unchanged, while still writing bits 7, 3 and 2.
- R6: Once bit 4 is 1, no status write clears it. While bit 4 is 1 or block protect is 11, a write with page select set is denied.
- R7: An `op_done` pulse clears status bit 6 and `idsel_o`.
- R8: If hardware protection becomes active while a status write is armed and `cs_n` is still low, the write is dropped with a deny pulse. A pin change after the commit has no effect on the status byte.
- R9: A refused request raises `deny_o` for one cycle and leaves the write-enable latch unchanged.
- R10: While `busy_in` is 1, every request is ignored: no grant, no deny and no change to the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select level, low while a command is in flight |
| wp_n | input | 1 | Write-protect pin level, low protects |
| busy_in | input | 1 | Internal programming cycle in progress |
| req_wren | input | 1 | Set-latch request pulse |
| req_wrdi | input | 1 | Clear-latch request pulse |
| req_wrsr | input | 1 | Status write request pulse |
| wrsr_data | input | 8 | Data byte of the status write |
| req_awr | input | 1 | Memory write request pulse |
| awr_addr | input | ADDR_W | Byte address of the memory write |
| op_done | input | 1 | End of a read or write operation |
| status_o | output | 8 | Status byte for reads |
| idsel_o | output | 1 | Identification page selected |
| grant_o | output | 1 | One-cycle write granted |
| deny_o | output | 1 | One-cycle write refused |

## Verification
Grant and deny for latch, array and page requests become visible one clock after the request, and the status byte changes in that same cycle. A status write gives its grant and its new byte one clock after the first cycle with `cs_n` high. A cancel deny appears one clock after the pin falls. The bench drives every input on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. Each pulse is therefore read in the single cycle it is due, and a missing or late pulse shows up as a mismatch.

// File: rtl/wp_pkg.sv
package wp_pkg;
   localparam int SB_PEN = 7;
   localparam int SB_IDS = 6;
   localparam int SB_LCK = 4;
   localparam int SB_BPH = 3;
   localparam int SB_BPL = 2;
   localparam int SB_WEL = 1;
   localparam int SB_BSY = 0;
   // bits a status write may change
   localparam logic [7:0] WR_MASK = 8'hDC;
   // bits that survive reset from the nonvolatile init value
   localparam logic [7:0] NV_MASK = 8'h9C;
   typedef enum logic [1:0] {BP_NONE = 2'b00, BP_QTR = 2'b01, BP_HALF = 2'b10, BP_ALL = 2'b11} bp_e;
endpackage

// File: rtl/wp_region_chk.sv
module wp_region_chk
   import wp_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input  logic [1:0]        bp,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int TOP = ADDR_W - 1;

   if (ADDR_W < 2) begin : g_bad_w
      $error("wp_region_chk: ADDR_W must be at least 2");
   end

   always_comb begin
      case (bp_e'(bp))
         BP_NONE: hit = 1'b0;
         BP_QTR:  hit = &addr[TOP -: 2];
         BP_HALF: hit = addr[TOP];
         default: hit = 1'b1;
      endcase
   end

   // R3: the whole array is covered by the widest setting
   always_comb begin
      if (bp == 2'b11) a_full_hit_r3: assert (hit);
   end
endmodule

// File: rtl/wp_grant_eval.sv
module wp_grant_eval
   import wp_pkg::*;
#(
   parameter bit ID_PAGE = 1'b1
) (
   input  logic       wel,
   input  logic       pen,
   input  logic       wp_n,
   input  logic       ids,
   input  logic       lck,
   input  logic [1:0] bp,
   input  logic       hit,
   output logic       hw_act,
   output logic       sr_ok,
   output logic       aw_ok
);
   logic page_ok;

   assign hw_act = pen & ~wp_n;
   assign sr_ok  = wel & ~hw_act;

   if (ID_PAGE) begin : g_page
      assign page_ok = wel & ~lck & (bp != 2'b11);
   end else begin : g_nopage
      assign page_ok = 1'b0;
   end

   assign aw_ok = ids ? page_ok : (wel & ~hit);
endmodule

// File: rtl/wp_status_ctl.sv
module wp_status_ctl
   import wp_pkg::*;
#(
   parameter int         ADDR_W  = 15,
   parameter logic [7:0] NV_INIT = 8'h00,
   parameter bit         ID_PAGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wp_n,
   input  logic              busy_in,
   input  logic              req_wren,
   input  logic              req_wrdi,
   input  logic              req_wrsr,
   input  logic [7:0]        wrsr_data,
   input  logic              req_awr,
   input  logic [ADDR_W-1:0] awr_addr,
   input  logic              op_done,
   output logic [7:0]        status_o,
   output logic              idsel_o,
   output logic              grant_o,
   output logic              deny_o
);
   localparam logic [7:0] CFG_RST = NV_INIT & NV_MASK;

   if ((NV_INIT & ~NV_MASK) != 8'h00) begin : g_bad_init
      $error("wp_status_ctl: NV_INIT sets a volatile or read-only bit");
   end

   logic [7:0] cfg_q, cfg_commit, wdat;
   logic [7:0] pend_dat_q;
   logic       pend_q, wel_q, grant_q, deny_q;
   logic       hit, hw_act, sr_ok, aw_ok, both;

   wp_region_chk #(.ADDR_W(ADDR_W)) u_region (
      .bp   (cfg_q[SB_BPH:SB_BPL]),
      .addr (awr_addr),
      .hit  (hit)
   );

   wp_grant_eval #(.ID_PAGE(ID_PAGE)) u_eval (
      .wel    (wel_q),
      .pen    (cfg_q[SB_PEN]),
      .wp_n   (wp_n),
      .ids    (cfg_q[SB_IDS]),
      .lck    (cfg_q[SB_LCK]),
      .bp     (cfg_q[SB_BPH:SB_BPL]),
      .hit    (hit),
      .hw_act (hw_act),
      .sr_ok  (sr_ok),
      .aw_ok  (aw_ok)
   );

   // merge an armed status byte into the current configuration
   always_comb begin
      wdat = pend_dat_q;
      both = pend_dat_q[SB_IDS] & pend_dat_q[SB_LCK];
      if (both) begin
         wdat[SB_IDS] = cfg_q[SB_IDS];
         wdat[SB_LCK] = cfg_q[SB_LCK];
      end else begin
         wdat[SB_LCK] = pend_dat_q[SB_LCK] | cfg_q[SB_LCK];
      end
      wdat[SB_IDS] = wdat[SB_IDS] & ID_PAGE;
      cfg_commit = (cfg_q & ~WR_MASK) | (wdat & WR_MASK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q      <= CFG_RST;
         pend_dat_q <= 8'h00;
         pend_q     <= 1'b0;
         wel_q      <= 1'b0;
         grant_q    <= 1'b0;
         deny_q     <= 1'b0;
      end else begin
         grant_q <= 1'b0;
         deny_q  <= 1'b0;
         if (op_done) cfg_q[SB_IDS] <= 1'b0;
         if (!busy_in) begin
            if (pend_q && cs_n) begin
               cfg_q   <= cfg_commit;
               wel_q   <= 1'b0;
               grant_q <= 1'b1;
               pend_q  <= 1'b0;
            end else if (pend_q && hw_act) begin
               deny_q <= 1'b1;
               pend_q <= 1'b0;
            end else if (req_wrsr) begin
               if (sr_ok) begin
                  pend_q     <= 1'b1;
                  pend_dat_q <= wrsr_data;
               end else begin
                  deny_q <= 1'b1;
               end
            end else if (req_awr) begin
               if (aw_ok) begin
                  grant_q <= 1'b1;
                  wel_q   <= 1'b0;
               end else begin
                  deny_q <= 1'b1;
               end
            end else if (req_wrdi) begin
               wel_q <= 1'b0;
            end else if (req_wren) begin
               wel_q <= 1'b1;
            end
         end
      end
   end

   assign status_o = cfg_q | {6'b0, wel_q, busy_in};
   assign idsel_o  = cfg_q[SB_IDS];
   assign grant_o  = grant_q;
   assign deny_o   = deny_q;

   // R6: the page lock never falls while out of reset
   p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[SB_LCK] |=> cfg_q[SB_LCK]);
   // R9: a refusal leaves the latch as it was
   p_deny_keeps_wel_r9: assert property (@(posedge clk) disable iff (!rst_n)
      deny_o |-> wel_q == $past(wel_q));
   // R10: nothing is granted or refused while busy
   p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_in |=> !grant_o && !deny_o);
   // R2: every grant leaves the latch cleared
   p_grant_drops_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> !wel_q);
   // R4: block protect moves only together with a grant
   p_bp_needs_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_o |-> cfg_q[SB_BPH:SB_BPL] == $past(cfg_q[SB_BPH:SB_BPL]));
endmodule

// File: tb/wp_status_ctl_tb.sv
module wp_status_ctl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, wp_n = 1'b1, busy_in = 1'b0;
   logic        req_wren = 1'b0, req_wrdi = 1'b0, req_wrsr = 1'b0, req_awr = 1'b0, op_done = 1'b0;
   logic [7:0]  wrsr_data = 8'h00;
   logic [14:0] awr_addr = '0;
   logic [7:0]  status_o;
   logic        idsel_o, grant_o, deny_o;
   int          errors = 0, checks = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   wp_status_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .busy_in(busy_in),
      .req_wren(req_wren), .req_wrdi(req_wrdi), .req_wrsr(req_wrsr), .wrsr_data(wrsr_data),
      .req_awr(req_awr), .awr_addr(awr_addr), .op_done(op_done),
      .status_o(status_o), .idsel_o(idsel_o), .grant_o(grant_o), .deny_o(deny_o)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // check the one-cycle result {grant,deny} right after a request edge
   task automatic res(input string tag, input logic g, input logic d);
      chk(tag, {6'b0, grant_o, deny_o}, {6'b0, g, d});
   endtask

   task automatic wren();
      req_wren = 1'b1; tick(); req_wren = 1'b0;
   endtask
   task automatic wrdi();
      req_wrdi = 1'b1; tick(); req_wrdi = 1'b0;
   endtask
   task automatic awr(input logic [14:0] a);
      awr_addr = a; req_awr = 1'b1; tick(); req_awr = 1'b0;
   endtask
   task automatic wrsr_req(input logic [7:0] d);
      cs_n = 1'b0; wrsr_data = d; req_wrsr = 1'b1; tick(); req_wrsr = 1'b0;
   endtask
   task automatic cs_rise();
      cs_n = 1'b1; tick();
   endtask
   // full accepted status write: enable, request, commit
   task automatic sr_write(input logic [7:0] d);
      wren(); wrsr_req(d); cs_rise();
   endtask

   task automatic t_reset();
      chk("R1 reset status", status_o, 8'h00);
      busy_in = 1'b1; #1;
      chk("R1 busy mirror", status_o, 8'h01);
      busy_in = 1'b0; #1;
   endtask

   task automatic t_latch();
      wren(); chk("R2 wren sets latch", status_o, 8'h02);
      wrdi(); chk("R2 wrdi clears latch", status_o, 8'h00);
   endtask

   task automatic t_array();
      awr(15'h0100); res("R9 array without latch", 1'b0, 1'b1);
      chk("R9 latch unchanged", status_o, 8'h00);
      wren(); awr(15'h0100); res("R3 array grant", 1'b1, 1'b0);
      chk("R2 grant clears latch", status_o, 8'h00);
   endtask

   task automatic t_status_bp();
      wren(); wrsr_req(8'h8F);
      chk("R4 armed not applied", status_o, 8'h02);
      cs_rise(); res("R4 commit grant", 1'b1, 1'b0);
      chk("R4 writable bits only", status_o, 8'h8C);
      wren(); awr(15'h0000); res("R3 full protect deny", 1'b0, 1'b1);
      sr_write(8'h04); chk("R3 set quarter", status_o, 8'h04);
      wren(); awr(15'h6000); res("R3 quarter protected", 1'b0, 1'b1);
      awr(15'h5FFF); res("R3 below quarter", 1'b1, 1'b0);
      sr_write(8'h08); chk("R3 set half", status_o, 8'h08);
      wren(); awr(15'h4000); res("R3 half protected", 1'b0, 1'b1);
      awr(15'h3FFF); res("R3 below half", 1'b1, 1'b0);
      sr_write(8'h80); chk("R4 pin enable set", status_o, 8'h80);
   endtask

   task automatic t_hw();
      wp_n = 1'b0;
      wren(); wrsr_req(8'h00); res("R4 hw protect refuses", 1'b0, 1'b1);
      cs_rise();
      chk("R9 status and latch kept", status_o, 8'h82);
      awr(15'h0010); res("R3 unprotected under hw", 1'b1, 1'b0);
      wp_n = 1'b1;
   endtask

   task automatic t_cancel();
      wren(); wrsr_req(8'h84);
      wp_n = 1'b0; tick(); res("R8 cancel deny", 1'b0, 1'b1);
      cs_rise(); res("R8 no commit", 1'b0, 1'b0);
      chk("R8 status kept", status_o, 8'h82);
      wp_n = 1'b1;
      wrsr_req(8'h88); cs_rise(); res("R8 commit", 1'b1, 1'b0);
      wp_n = 1'b0; tick();
      chk("R8 late pin no effect", status_o, 8'h88);
      wp_n = 1'b1;
      sr_write(8'h00); chk("R4 clear config", status_o, 8'h00);
   endtask

   task automatic t_page();
      sr_write(8'h58); chk("R5 both bits kept", status_o, 8'h08);
      sr_write(8'h40); chk("R4 page select set", {7'b0, idsel_o}, 8'h01);
      wren(); awr(15'h0005); res("R6 page write grant", 1'b1, 1'b0);
      op_done = 1'b1; tick(); op_done = 1'b0;
      chk("R7 select cleared", status_o, 8'h00);
      sr_write(8'h4C);
      wren(); awr(15'h0001); res("R6 page with full bp", 1'b0, 1'b1);
      wrdi();
      sr_write(8'h10); chk("R6 lock set", status_o, 8'h10);
      sr_write(8'h00); chk("R6 lock sticky", status_o, 8'h10);
      sr_write(8'h40);
      wren(); awr(15'h0002); res("R6 locked page deny", 1'b0, 1'b1);
      op_done = 1'b1; tick(); op_done = 1'b0;
      chk("R7 select cleared again", status_o, 8'h12);
   endtask

   task automatic t_busy();
      wrdi(); busy_in = 1'b1;
      wren(); chk("R10 wren ignored", status_o, 8'h11);
      awr(15'h0000); res("R10 no result", 1'b0, 1'b0);
      busy_in = 1'b0; #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latch();
      t_array();
      t_status_bp();
      t_hw();
      t_cancel();
      t_page();
      t_busy();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule